// File: doc/BRIEF.md
# Iterative Set-Bit Counter

This block counts the 1 bits of a WIDTH-bit word over several clock cycles. A pulse on `go` makes it take a copy of `din` into a working register and set an internal tally to zero. On each following cycle it removes the lowest 1 bit of the working register, using the identity x AND (x - 1), and adds one to the tally. The loop stops on the first cycle in which the working register is zero. The final tally is then written to `count` and `done` is raised.

The number of cycles depends on how many bits are set, not on WIDTH. A sparse word therefore finishes in a few cycles. A full word takes WIDTH iterations plus one completion cycle. `done` stays high until the user starts the next computation with `go`. This lets a slow consumer read `count` at any time.

Top module: `bitcount_iter`

## Requirements
- R1: While `rst` is high, and on the first cycle after it falls, `count` reads 0 and `done` reads 0.
- R2: When `go` is sampled high while no computation is running, a new computation starts. This holds both after reset and while `done` is high. `done` reads 0 on the cycle right after that clock edge.
- R3: At completion, `count` equals the number of 1 bits in the captured word. Its width is $clog2(WIDTH+1), so an all-ones word reports exactly WIDTH and an all-zero word reports 0.
- R4: `done` rises exactly P+1 clock edges after the edge that sampled `go`, where P is the number of 1 bits in the captured word. An all-zero word therefore completes after one edge.
- R5: Once high, `done` stays high, and `count` keeps its value, for as long as `go` stays low.
- R6: During a computation, `count` keeps the previous result. It changes only on the edge where `done` rises.
- R7: A `go` pulse sampled while a computation is running is ignored. The result and the latency are the same as without the pulse.
- R8: The word is captured on the edge that samples `go`. Later changes on `din` do not affect the running computation.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| go | input | 1 | Start request, sampled on the rising edge |
| din | input | WIDTH | Word whose 1 bits are counted |
| count | output | $clog2(WIDTH+1) | Result of the last completed computation |
| done | output | 1 | High from completion until the next start |

## Verification
On every cycle the assertions check the `done` protocol:
- `done` falls after an accepted start and holds while `go` is low;
- `done` rises on the cycle after the working register empties;
- `done` is never high while the loop runs;
- `count` changes only with a rising `done` and never exceeds WIDTH.

The correctness of the value itself and the exact latency P+1 can only be shown by the bench. It compares each result against a computed bit count over directed words (zero, all ones, single bits, alternating patterns) and over random words of varied density. It also toggles `din` and pulses `go` in the middle of a run to show that capture and busy-time start requests behave as required.

// File: rtl/bitcount_pkg.sv
package bitcount_pkg;

    typedef enum logic [0:0] {
        BC_IDLE = 1'b0,
        BC_RUN  = 1'b1
    } bc_state_e;

endpackage

// File: rtl/bitcount_lsb_clear.sv
// Combinational step: drops the least significant 1 bit of a word.
module bitcount_lsb_clear #(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] word_i,
    output logic [WIDTH-1:0] word_o
);

    logic [WIDTH-1:0] minus_one;

    always_comb begin
        minus_one = word_i - WIDTH'(1);
        word_o    = word_i & minus_one;
    end

endmodule

// File: rtl/bitcount_dp.sv
// Datapath: working register, running tally, held result.
module bitcount_dp #(
    parameter int WIDTH = 32,
    localparam int CW   = $clog2(WIDTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic             step,
    input  logic             finish,
    input  logic [WIDTH-1:0] din,
    output logic             work_zero,
    output logic [CW-1:0]    result
);

    typedef struct packed {
        logic [WIDTH-1:0] work;
        logic [CW-1:0]    tally;
        logic [CW-1:0]    res;
    } dp_regs_t;

    dp_regs_t         q, d;
    logic [WIDTH-1:0] work_next;

    bitcount_lsb_clear #(.WIDTH(WIDTH)) u_clr (
        .word_i (q.work),
        .word_o (work_next)
    );

    always_comb begin
        d = q;
        if (load) begin
            d.work  = din;
            d.tally = '0;
        end else if (step) begin
            d.work  = work_next;
            d.tally = q.tally + CW'(1);
        end
        if (finish) begin
            d.res = q.tally;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign work_zero = (q.work == '0);
    assign result    = q.res;

endmodule

// File: rtl/bitcount_ctrl.sv
// Controller: idle/run sequencing and the done flag.
module bitcount_ctrl
    import bitcount_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic go,
    input  logic work_zero,
    output logic load,
    output logic step,
    output logic finish,
    output logic busy,
    output logic done
);

    typedef struct packed {
        bc_state_e st;
        logic      done;
    } ctrl_regs_t;

    ctrl_regs_t q, d;

    always_comb begin
        d      = q;
        load   = 1'b0;
        step   = 1'b0;
        finish = 1'b0;
        unique case (q.st)
            BC_IDLE: begin
                if (go) begin
                    load   = 1'b1;
                    d.st   = BC_RUN;
                    d.done = 1'b0;
                end
            end
            BC_RUN: begin
                if (work_zero) begin
                    finish = 1'b1;
                    d.st   = BC_IDLE;
                    d.done = 1'b1;
                end else begin
                    step = 1'b1;
                end
            end
            default: d.st = BC_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            q.st   <= BC_IDLE;
            q.done <= 1'b0;
        end else begin
            q <= d;
        end
    end

    assign busy = (q.st == BC_RUN);
    assign done = q.done;

endmodule

// File: rtl/bitcount_iter.sv
module bitcount_iter #(
    parameter int WIDTH = 32,
    localparam int CW   = $clog2(WIDTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             go,
    input  logic [WIDTH-1:0] din,
    output logic [CW-1:0]    count,
    output logic             done
);

    logic load, step, finish, busy, work_zero;

    bitcount_ctrl u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .go        (go),
        .work_zero (work_zero),
        .load      (load),
        .step      (step),
        .finish    (finish),
        .busy      (busy),
        .done      (done)
    );

    bitcount_dp #(.WIDTH(WIDTH)) u_dp (
        .clk       (clk),
        .rst       (rst),
        .load      (load),
        .step      (step),
        .finish    (finish),
        .din       (din),
        .work_zero (work_zero),
        .result    (count)
    );

endmodule

// File: rtl/bitcount_iter_chk.sv
module bitcount_iter_chk #(
    parameter int WIDTH = 32,
    localparam int CW   = $clog2(WIDTH + 1)
) (
    input logic          clk,
    input logic          rst,
    input logic          go,
    input logic          done,
    input logic [CW-1:0] count,
    input logic          busy,
    input logic          work_zero
);

    p_done_drop_r2: assert property (@(posedge clk) disable iff (rst)
        (done && go) |=> !done);

    p_count_range_r3: assert property (@(posedge clk) disable iff (rst)
        (32'(count) <= WIDTH));

    p_finish_r4: assert property (@(posedge clk) disable iff (rst)
        (busy && work_zero) |=> (done && !busy));

    p_done_hold_r5: assert property (@(posedge clk) disable iff (rst)
        (done && !go) |=> (done && $stable(count)));

    p_count_stable_r6: assert property (@(posedge clk) disable iff (rst)
        !$rose(done) |-> $stable(count));

    p_busy_no_done_r7: assert property (@(posedge clk) disable iff (rst)
        busy |-> !done);

    p_go_ignored_r7: assert property (@(posedge clk) disable iff (rst)
        (busy && !work_zero) |=> busy);

endmodule

bind bitcount_iter bitcount_iter_chk #(.WIDTH(WIDTH)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .go        (go),
    .done      (done),
    .count     (count),
    .busy      (busy),
    .work_zero (work_zero)
);

// File: tb/sim_bitcount_iter.sv
module sim_bitcount_iter;

    localparam int W          = 32;
    localparam int CW         = $clog2(W + 1);
    localparam int CLK_PERIOD = 10;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          go  = 1'b0;
    logic [W-1:0]  din = '0;
    logic [CW-1:0] count;
    logic          done;

    int total = 0;
    int bad   = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    bitcount_iter #(.WIDTH(W)) u0 (
        .clk   (clk),
        .rst   (rst),
        .go    (go),
        .din   (din),
        .count (count),
        .done  (done)
    );

    function automatic int ref_pop(input logic [W-1:0] w);
        int n = 0;
        for (int i = 0; i < W; i++) n += int'(w[i]);
        return n;
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // One computation. scramble: change din after capture (R8).
    // poke: pulse go while the loop runs (R7).
    task automatic run_one(input logic [W-1:0] w, input bit scramble, input bit poke);
        int            exp_n = ref_pop(w);
        int            lat   = 0;
        bit            seen  = 0;
        logic [CW-1:0] prev  = count;
        string         tag   = scramble ? "R8" : (poke ? "R7" : "R3");
        din = w;
        go  = 1'b1;
        @(posedge clk);
        @(negedge clk);
        go = 1'b0;
        chk(done == 1'b0, "R2 done low after go", int'(done), 0);
        if (scramble) din = ~w;
        for (int i = 1; i <= W + 4 && !seen; i++) begin
            if (poke && i == 1) go = 1'b1;
            @(posedge clk);
            @(negedge clk);
            go = 1'b0;
            if (done) begin
                seen = 1;
                lat  = i;
            end else begin
                chk(count == prev, "R6 count held while running", int'(count), int'(prev));
            end
        end
        chk(seen, "R4 done never rose", int'(seen), 1);
        chk(lat == exp_n + 1, {tag, "/R4 latency"}, lat, exp_n + 1);
        chk(int'(count) == exp_n, {tag, " count value"}, int'(count), exp_n);
        for (int i = 0; i < 2; i++) begin
            @(negedge clk);
            chk(done == 1'b1, "R5 done held", int'(done), 1);
            chk(int'(count) == exp_n, "R5 count held", int'(count), exp_n);
        end
    endtask

    initial begin
        repeat (CLK_PERIOD * 20000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog actual=expired expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [W-1:0] w;
        void'($urandom(32'd2718));
        repeat (3) @(negedge clk);
        chk(done == 1'b0, "R1 done in reset", int'(done), 0);
        chk(count == '0, "R1 count in reset", int'(count), 0);
        rst = 1'b0;
        @(negedge clk);
        chk(done == 1'b0, "R1 done after reset", int'(done), 0);
        chk(count == '0, "R1 count after reset", int'(count), 0);

        // R2: first start comes with done low
        run_one(32'h0000_0000, 0, 0);   // R4: zero word, one edge
        run_one('1, 0, 0);              // R3: full word reports W
        run_one(32'h0000_0000, 0, 0);
        run_one(32'h8000_0000, 0, 0);
        run_one(32'h0000_0001, 0, 0);
        run_one(32'h5555_5555, 0, 0);
        run_one(32'hAAAA_AAAA, 0, 0);
        run_one(32'hF0F0_0F0F, 1, 0);   // R8
        run_one(32'h0000_0000, 1, 0);   // R8: zero word, din flips to all ones
        run_one(32'h1234_8001, 0, 1);   // R7
        run_one('1, 0, 1);              // R7

        for (int k = 0; k < 300; k++) begin
            w = W'({$urandom(), $urandom()});
            case (k % 4)
                0: w = w & W'($urandom());
                1: w = w | W'($urandom());
                default: ;
            endcase
            run_one(w, (k % 7) == 3, (k % 5) == 2);
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule